// File: doc/BRIEF.md
# Thermal Over-Limit Alert with Consecutive-Fault Filter

This block watches a stream of 9-bit two's complement temperature samples, each given with a one-cycle valid pulse. It compares every sample against an upper trip word and a lower trip word, and drives the output enable of an open-drain alert pad. A sample only counts toward an alert when a programmed number of qualifying samples arrive in a row. This filters out isolated noisy readings.

Two behaviours are available. As a thermostat (comparator mode), the alert follows the temperature with hysteresis. It turns on after a run of samples above the upper trip and turns off after a run of samples below the lower trip. As a latched interrupt, each qualifying run raises the alert. The alert then stays raised until software reads any register or shutdown is entered. The crossing being watched alternates between the upper trip and the lower trip.

The configuration byte, the trip words and the read strobe come from a register file outside this block. The conversion timer that produces the samples is also outside it.

Top module: `thermo_alert`

## Requirements
- R1: In comparator mode (cfg_byte bit 1 = 0) with the alert inactive, the alert becomes active once the required number of consecutive samples are strictly greater than the upper trip value. A sample equal to the upper trip does not qualify.
- R2: In comparator mode with the alert active, it becomes inactive only after the required number of consecutive samples are strictly less than the lower trip value. Samples between the two trips leave it active.
- R3: cfg_byte bits 4:3 select the required run length: 00 → 1, 01 → 2, 10 → 4, 11 → 6.
- R4: A valid sample that fails the condition being watched clears the run. A change of bits 4:3 or of bit 1 also clears the run. A qualifying sample in the same cycle as such a change counts as the first of a new run.
- R5: In interrupt mode (bit 1 = 1), after reset the first event is a run above the upper trip. An event latches the alert until a read strobe or entry into shutdown. Samples arriving while the alert is latched are ignored.
- R6: In interrupt mode, the watched condition alternates after every event: above the upper trip, then below the lower trip, then above the upper trip again, and so on.
- R7: If an interrupt event and a read strobe occur in the same cycle, the alert ends up latched.
- R8: While bit 0 (shutdown) is 1, valid samples are ignored and the run count holds. Entering shutdown (bit 0 going 0 → 1) clears a latched interrupt. It leaves the comparator-mode state unchanged.
- R9: Each trip value is taken from bits 15:7 of its 16-bit word as a signed number, and bits 6:0 are ignored. Samples are signed 9-bit values in half-degree units.
- R10: alert_oe equals the internal active state XOR cfg_byte bit 2. With bit 2 = 0, alert_oe = 1 (pad pulled low) when active.
- R11: After reset the alert is inactive, the run count is zero, and interrupt mode first watches the upper trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle pulse marking a new sample |
| smp_temp | input | 9 | Signed sample, half-degree units |
| hi_word | input | 16 | Upper trip word, bits 15:7 used |
| lo_word | input | 16 | Lower trip word, bits 15:7 used |
| cfg_byte | input | 8 | Bit 0 shutdown, bit 1 mode, bit 2 polarity, bits 4:3 run code |
| rd_pulse | input | 1 | One-cycle strobe for any register read |
| alert_oe | output | 1 | Pad output enable; 1 pulls the pin low |

## Verification
The assertions assume that reset is applied before the first sample. They also assume that smp_vld and rd_pulse are single-cycle strobes sampled on the rising edge. Configuration changes that land in shutdown are excluded from the hold checks through the run-clear signal. The stimulus changes every input only at the falling clock edge and holds it for a full cycle, so each sample, read or configuration change is seen by exactly one rising edge. Trip words are held constant within each test section, so every expected result depends only on the sequence of samples and strobes.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

  // configuration byte bit positions (decoded by the register file too)
  localparam int unsigned CFG_SD_BIT   = 0;
  localparam int unsigned CFG_MODE_BIT = 1;
  localparam int unsigned CFG_POL_BIT  = 2;
  localparam int unsigned CFG_RUN_LO   = 3;
  localparam int unsigned CFG_RUN_W    = 2;

  typedef enum logic {
    MODE_THERMO = 1'b0,
    MODE_LATCH  = 1'b1
  } alert_mode_e;

  // run-length code to number of consecutive qualifying samples
  function automatic int unsigned run_need(input logic [CFG_RUN_W-1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/ta_threshold.sv
module ta_threshold #(
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned WORD_W = 16
) (
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  output logic              over_hi,
  output logic              under_lo
);
  localparam int unsigned PAD_W = WORD_W - TEMP_W;

  logic signed [TEMP_W-1:0] hi_t;
  logic signed [TEMP_W-1:0] lo_t;
  logic signed [TEMP_W-1:0] smp_s;

  assign hi_t  = hi_word[WORD_W-1 -: TEMP_W];
  assign lo_t  = lo_word[WORD_W-1 -: TEMP_W];
  assign smp_s = smp_temp;

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^{hi_word[PAD_W-1:0], lo_word[PAD_W-1:0]};
    end
  endgenerate

  assign over_hi  = smp_s > hi_t;
  assign under_lo = smp_s < lo_t;
endmodule

// File: rtl/ta_fault_run.sv
module ta_fault_run
  import thermo_alert_pkg::*;
#(
  parameter int unsigned RUN_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_RUN_W-1:0] run_code,
  input  logic                 mode_irq,
  input  logic                 smp_en,
  input  logic                 hit,
  output logic                 fault_evt,
  output logic                 run_clr,
  output logic [RUN_W-1:0]     run_cnt,
  output logic [RUN_W-1:0]     run_goal
);
  logic [CFG_RUN_W-1:0] code_q;
  logic                 mode_q;
  logic [RUN_W-1:0]     base;
  logic [RUN_W-1:0]     nxt;

  assign run_goal  = RUN_W'(run_need(run_code));
  assign run_clr   = (run_code != code_q) || (mode_irq != mode_q);
  assign base      = run_clr ? '0 : run_cnt;
  assign nxt       = base + RUN_W'(1);
  assign fault_evt = smp_en && hit && (nxt >= run_goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      mode_q  <= 1'b0;
      run_cnt <= '0;
    end else begin
      code_q <= run_code;
      mode_q <= mode_irq;
      if (smp_en) begin
        run_cnt <= (hit && !fault_evt) ? nxt : '0;
      end else if (run_clr) begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ta_alert_state.sv
module ta_alert_state (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_irq,
  input  logic over_hi,
  input  logic under_lo,
  input  logic fault_evt,
  input  logic clr_req,
  output logic hit,
  output logic active,
  output logic cmp_active,
  output logic irq_latched
);
  logic seek_low;

  always_comb begin
    if (mode_irq) begin
      hit = !irq_latched && (seek_low ? under_lo : over_hi);
    end else begin
      hit = cmp_active ? under_lo : over_hi;
    end
  end

  assign active = mode_irq ? irq_latched : cmp_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_active  <= 1'b0;
      irq_latched <= 1'b0;
      seek_low    <= 1'b0;
    end else begin
      if (!mode_irq && fault_evt) begin
        cmp_active <= !cmp_active;
      end
      if (mode_irq) begin
        if (fault_evt) begin
          irq_latched <= 1'b1;
          seek_low    <= !seek_low;
        end else if (clr_req) begin
          irq_latched <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int unsigned TEMP_W = 9,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RUN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [7:0]        cfg_byte,
  input  logic              rd_pulse,
  output logic              alert_oe
);
  logic                 sd_now;
  logic                 sd_q;
  logic                 sd_rise;
  logic                 mode_irq;
  logic                 pol_hi;
  logic [CFG_RUN_W-1:0] run_code;
  logic                 smp_en;
  logic                 over_hi;
  logic                 under_lo;
  logic                 run_hit;
  logic                 fault_evt;
  logic                 run_clr;
  logic [RUN_W-1:0]     run_cnt;
  logic [RUN_W-1:0]     run_goal;
  logic                 clr_req;
  logic                 active;
  logic                 cmp_active;
  logic                 irq_latched;
  logic                 unused_cfg;

  assign sd_now   = cfg_byte[CFG_SD_BIT];
  assign mode_irq = cfg_byte[CFG_MODE_BIT] == MODE_LATCH;
  assign pol_hi   = cfg_byte[CFG_POL_BIT];
  assign run_code = cfg_byte[CFG_RUN_LO +: CFG_RUN_W];
  assign unused_cfg = ^cfg_byte[7:CFG_RUN_LO+CFG_RUN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_now;
  end

  assign sd_rise = sd_now && !sd_q;
  assign smp_en  = smp_vld && !sd_now;
  assign clr_req = rd_pulse || sd_rise;

  ta_threshold #(.TEMP_W(TEMP_W), .WORD_W(WORD_W)) u_thr (
    .smp_temp (smp_temp),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .over_hi  (over_hi),
    .under_lo (under_lo)
  );

  ta_fault_run #(.RUN_W(RUN_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_code  (run_code),
    .mode_irq  (mode_irq),
    .smp_en    (smp_en),
    .hit       (run_hit),
    .fault_evt (fault_evt),
    .run_clr   (run_clr),
    .run_cnt   (run_cnt),
    .run_goal  (run_goal)
  );

  ta_alert_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_irq    (mode_irq),
    .over_hi     (over_hi),
    .under_lo    (under_lo),
    .fault_evt   (fault_evt),
    .clr_req     (clr_req),
    .hit         (run_hit),
    .active      (active),
    .cmp_active  (cmp_active),
    .irq_latched (irq_latched)
  );

  assign alert_oe = active ^ pol_hi;
endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk #(
  parameter int unsigned RUN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_now,
  input logic             mode_irq,
  input logic             rd_pulse,
  input logic             smp_en,
  input logic             run_hit,
  input logic             fault_evt,
  input logic             run_clr,
  input logic [RUN_W-1:0] run_cnt,
  input logic [RUN_W-1:0] run_goal,
  input logic             cmp_active,
  input logic             irq_latched
);
  AST_RUN_BELOW_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_clr |-> (run_cnt < run_goal)); // R3

  AST_EVT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (smp_en && run_hit)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && rd_pulse && !fault_evt) |=> !irq_latched); // R5

  AST_LATCH_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && irq_latched) |-> !run_hit); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_irq && fault_evt) |=> irq_latched); // R7

  AST_SD_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_now && $past(sd_now) && !$past(run_clr)) |-> $stable(run_cnt)); // R8

  AST_SD_THERMO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_now && $past(sd_now)) |-> $stable(cmp_active)); // R8
endmodule

bind thermo_alert thermo_alert_chk #(.RUN_W(RUN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sd_now      (sd_now),
  .mode_irq    (mode_irq),
  .rd_pulse    (rd_pulse),
  .smp_en      (smp_en),
  .run_hit     (run_hit),
  .fault_evt   (fault_evt),
  .run_clr     (run_clr),
  .run_cnt     (run_cnt),
  .run_goal    (run_goal),
  .cmp_active  (cmp_active),
  .irq_latched (irq_latched)
);

// File: tb/test_thermo_alert.sv
module test_thermo_alert;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [8:0]  smp_temp = '0;
  logic [15:0] hi_word = 16'h5000;   // 80.0 -> 160
  logic [15:0] lo_word = 16'h4B00;   // 75.0 -> 150
  logic [7:0]  cfg_byte = 8'h00;
  logic        rd_pulse = 1'b0;
  logic        alert_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_alert i_thermo_alert (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
    .hi_word(hi_word), .lo_word(lo_word), .cfg_byte(cfg_byte),
    .rd_pulse(rd_pulse), .alert_oe(alert_oe)
  );

  // {cfg, valid, sample, read, expected alert_oe}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 9'd100, 1'b0, 1'b0},
    {8'h00, 1'b1, 9'd161, 1'b0, 1'b1},
    {8'h00, 1'b1, 9'd155, 1'b0, 1'b1},
    {8'h00, 1'b1, 9'd149, 1'b0, 1'b0},
    {8'h00, 1'b1, 9'd160, 1'b0, 1'b0},
    {8'h08, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h08, 1'b1, 9'd100, 1'b0, 1'b0},
    {8'h08, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h08, 1'b1, 9'd170, 1'b0, 1'b1},
    {8'h10, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h10, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h10, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h10, 1'b1, 9'd100, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h18, 1'b1, 9'd170, 1'b0, 1'b1},
    {8'h1C, 1'b0, 9'd0,   1'b0, 1'b0},
    {8'h04, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h00, 1'b0, 9'd0,   1'b0, 1'b0},
    {8'h02, 1'b1, 9'd170, 1'b0, 1'b1},
    {8'h02, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h02, 1'b0, 9'd0,   1'b1, 1'b0},
    {8'h02, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h02, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h02, 1'b0, 9'd0,   1'b0, 1'b1},
    {8'h03, 1'b0, 9'd0,   1'b0, 1'b0},
    {8'h03, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h02, 1'b1, 9'd170, 1'b0, 1'b1},
    {8'h02, 1'b0, 9'd0,   1'b1, 1'b0},
    {8'h00, 1'b1, 9'd170, 1'b0, 1'b1},
    {8'h01, 1'b0, 9'd0,   1'b0, 1'b1},
    {8'h01, 1'b1, 9'd100, 1'b0, 1'b1},
    {8'h00, 1'b1, 9'd100, 1'b0, 1'b0},
    {8'h08, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h10, 1'b0, 9'd0,   1'b0, 1'b0},
    {8'h10, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h10, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h10, 1'b1, 9'd170, 1'b0, 1'b0},
    {8'h10, 1'b1, 9'd170, 1'b0, 1'b1}
  };

  function automatic string vec_req(input int i);
    if (i <= 1 || i == 4) return "R1";
    if (i <= 3)  return "R2";
    if (i <= 8)  return "R3 R4";
    if (i <= 18) return "R3";
    if (i <= 21) return "R10";
    if (i <= 27) return "R5 R6";
    if (i <= 29) return "R8";
    if (i <= 31) return "R6";
    if (i <= 35) return "R8";
    return "R4";
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: alert_oe=%0b expected %0b", req, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge, observe at next falling edge
  task automatic step(input logic [7:0] cfg, input logic vld,
                      input logic [8:0] t, input logic rd);
    cfg_byte = cfg; smp_vld = vld; smp_temp = t; rd_pulse = rd;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0; rd_pulse = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_byte = 8'h00; smp_vld = 1'b0; rd_pulse = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R11 and R10 while held in reset
    check("R11", alert_oe, 1'b0);
    cfg_byte = 8'h04;
    #1 check("R10", alert_oe, 1'b1);
    cfg_byte = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", alert_oe, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][19:12], VEC[i][11], VEC[i][10:2], VEC[i][1]);
      check(vec_req(i), alert_oe, VEC[i][0]);
    end

    // R7: event and read in the same cycle leaves the alert latched
    do_reset();
    step(8'h02, 1'b1, 9'd170, 1'b1);
    check("R7", alert_oe, 1'b1);
    step(8'h02, 1'b0, 9'd0, 1'b1);
    check("R5", alert_oe, 1'b0);

    // R8: run count holds through shutdown
    do_reset();
    step(8'h08, 1'b1, 9'd170, 1'b0);
    check("R8", alert_oe, 1'b0);
    step(8'h09, 1'b1, 9'd170, 1'b0);
    check("R8", alert_oe, 1'b0);
    step(8'h08, 1'b1, 9'd170, 1'b0);
    check("R8", alert_oe, 1'b1);

    // R9: negative trips, low bits of the trip word ignored
    do_reset();
    hi_word = 16'hF67F;   // -20 half-degrees, low bits set
    lo_word = 16'hEC00;   // -40 half-degrees
    step(8'h00, 1'b1, 9'h1F6, 1'b0);   // -10
    check("R9", alert_oe, 1'b1);
    step(8'h00, 1'b1, 9'h1CE, 1'b0);   // -50
    check("R9", alert_oe, 1'b0);
    step(8'h00, 1'b1, 9'h1EC, 1'b0);   // -20, equal to upper trip
    check("R9", alert_oe, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run still busy, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule